// File: doc/BRIEF.md
# Dual-Source System Clock Controller

This block chooses the system clock from two sources. One is a slow timebase clock that always runs. The other is a fast oscillator that can be turned on and off. A 3-bit control word, written in the timebase clock domain, sets three things: the oscillator type (RC or ceramic), whether the oscillator runs, and which source the CPU clock should use.

When the oscillator is enabled, a counter running on the timebase clock measures a start-up settling interval. The length of that interval depends on the oscillator type. When the counter finishes, a read-only ready flag goes high.

A request for the fast source is held pending until ready is high. A small state machine then hands the output over through a glitch-free multiplexer. If the enable bit is cleared while the fast source is in use, the block first moves the clock back to the timebase. Only after that does it let the oscillator stop.

The state machine has four states:
- ST_LO: the timebase drives the output.
- ST_TO_HI: waiting for the fast gate to open.
- ST_HI: the fast source drives the output.
- ST_TO_LO: waiting for the fast gate to close.

Its transitions are:
- ST_LO to ST_TO_HI when the effective request is high, meaning source bit, enable bit and ready are all set.
- ST_TO_HI to ST_HI once the synchronized fast gate is seen open.
- ST_HI to ST_TO_LO when the effective request drops.
- ST_TO_LO to ST_LO once the synchronized fast gate is seen closed.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, cfg_rd is 3'b000, hs_ready, on_hi and osc_on are 0, and sys_clk follows lo_clk.
- R2: A write loads wr_data and cfg_rd reads it back with the same layout: bit 0 is the source request (1 = fast source), bit 1 is the oscillator enable, and bit 2 is the oscillator type (0 = RC, 1 = ceramic).
- R3: In RC mode, hs_ready is 0 after the first RC_CNT-1 lo_clk edges that follow the enabling write edge and is 1 after edge RC_CNT. RC_CNT is ceil(LO_HZ × RC_US / 1e6).
- R4: In ceramic mode the same rule holds with CER_CNT = ceil(LO_HZ × CER_US / 1e6).
- R5: A write to the type bit is ignored while the enable bit is 1.
- R6: While hs_ready is 0, a source request leaves on_hi at 0. Once ready is set, on_hi rises within 20 lo_clk cycles.
- R7: While on_hi is 1, sys_clk has the period of hi_clk. While the block is back in low speed, sys_clk has the period of lo_clk.
- R8: No high or low phase of sys_clk is shorter than half a hi_clk period. The two source gates are never open at the same time.
- R9: osc_on stays 1 until the fast source has been deselected, even if the enable bit is cleared while on_hi is 1. osc_on then drops within 20 cycles.
- R10: Clearing the enable bit drops hs_ready right after that write edge and restarts the settling count.
- R11: Clearing the source bit while the enable bit is still set returns on_hi to 0 within 20 cycles and keeps osc_on at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lo_clk | input | 1 | Timebase clock; register and settling domain |
| hi_clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe (lo_clk domain) |
| wr_data | input | 3 | Control write data |
| cfg_rd | output | 3 | Control register readback |
| hs_ready | output | 1 | Fast oscillator settled |
| on_hi | output | 1 | Fast source is driving sys_clk |
| osc_on | output | 1 | Enable to the fast oscillator |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
The assertions assume three things about the inputs:
- Both clocks toggle freely while reset is released.
- wr_en and wr_data change only away from the rising edge of lo_clk.
- hi_clk runs whenever osc_on is high.

The stimulus keeps to these assumptions. Every write is driven on a falling edge of lo_clk. hi_clk runs continuously at a period unrelated to lo_clk. This lets the handover synchronizers settle as they would with a real oscillator.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        ST_LO    = 2'd0,
        ST_TO_HI = 2'd1,
        ST_HI    = 2'd2,
        ST_TO_LO = 2'd3
    } sw_state_t;

    localparam int B_SRC = 0;
    localparam int B_EN  = 1;
    localparam int B_TYP = 2;
endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
    import sclk_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int RC_CNT  = 10,
    parameter int CER_CNT = 328
) (
    input  logic       lo_clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output logic       src_bit,
    output logic       en_bit,
    output logic       typ_bit,
    output logic       ready
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim = typ_bit ? CNT_W'(CER_CNT) : CNT_W'(RC_CNT);

    always_ff @(posedge lo_clk or negedge rst_n) begin
        if (!rst_n) begin
            src_bit <= 1'b0;
            en_bit  <= 1'b0;
            typ_bit <= 1'b0;
        end else if (wr_en) begin
            src_bit <= wr_data[B_SRC];
            en_bit  <= wr_data[B_EN];
            if (!en_bit)
                typ_bit <= wr_data[B_TYP];
        end
    end

    always_ff @(posedge lo_clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en_bit)
            cnt <= '0;
        else if (cnt != lim)
            cnt <= cnt + 1'b1;
    end

    assign ready = en_bit && (cnt == lim);
endmodule

// File: rtl/sclk_fsm.sv
module sclk_fsm
    import sclk_pkg::*;
(
    input  logic lo_clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic hi_seen,
    output logic sel_hi,
    output logic on_hi,
    output logic osc_hold
);
    sw_state_t state, nxt;

    always_ff @(posedge lo_clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LO;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LO:    if (want_hi)  nxt = ST_TO_HI;
            ST_TO_HI: if (hi_seen)  nxt = ST_HI;
            ST_HI:    if (!want_hi) nxt = ST_TO_LO;
            ST_TO_LO: if (!hi_seen) nxt = ST_LO;
            default:                nxt = ST_LO;
        endcase
    end

    always_comb begin
        sel_hi   = 1'b0;
        on_hi    = 1'b0;
        osc_hold = 1'b1;
        unique case (state)
            ST_LO:    osc_hold = 1'b0;
            ST_TO_HI: sel_hi = 1'b1;
            ST_HI:    begin sel_hi = 1'b1; on_hi = 1'b1; end
            ST_TO_LO: ;
            default:  osc_hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/sclk_gmux.sv
module sclk_gmux #(
    parameter int SYNC_N = 2
) (
    input  logic lo_clk,
    input  logic hi_clk,
    input  logic rst_n,
    input  logic sel_hi,
    output logic sys_clk,
    output logic lo_gate,
    output logic hi_gate,
    output logic hi_seen
);
    logic [SYNC_N-1:0] lo_sync, hi_sync, seen_sync;

    always_ff @(posedge lo_clk or negedge rst_n) begin
        if (!rst_n) lo_sync <= '1;
        else        lo_sync <= {lo_sync[SYNC_N-2:0], ~sel_hi & ~hi_gate};
    end

    always_ff @(negedge lo_clk or negedge rst_n) begin
        if (!rst_n) lo_gate <= 1'b1;
        else        lo_gate <= lo_sync[SYNC_N-1];
    end

    always_ff @(posedge hi_clk or negedge rst_n) begin
        if (!rst_n) hi_sync <= '0;
        else        hi_sync <= {hi_sync[SYNC_N-2:0], sel_hi & ~lo_gate};
    end

    always_ff @(negedge hi_clk or negedge rst_n) begin
        if (!rst_n) hi_gate <= 1'b0;
        else        hi_gate <= hi_sync[SYNC_N-1];
    end

    always_ff @(posedge lo_clk or negedge rst_n) begin
        if (!rst_n) seen_sync <= '0;
        else        seen_sync <= {seen_sync[SYNC_N-2:0], hi_gate};
    end

    assign hi_seen = seen_sync[SYNC_N-1];
    assign sys_clk = (lo_clk & lo_gate) | (hi_clk & hi_gate);
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
    import sclk_pkg::*;
#(
    parameter int LO_HZ  = 32768,
    parameter int RC_US  = 300,
    parameter int CER_US = 10000
) (
    input  logic       lo_clk,
    input  logic       hi_clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output logic [2:0] cfg_rd,
    output logic       hs_ready,
    output logic       on_hi,
    output logic       osc_on,
    output logic       sys_clk
);
    localparam longint RC_L   = (longint'(LO_HZ) * RC_US  + 999999) / 1000000;
    localparam longint CER_L  = (longint'(LO_HZ) * CER_US + 999999) / 1000000;
    localparam int     RC_CNT  = int'(RC_L);
    localparam int     CER_CNT = int'(CER_L);
    localparam int     MAX_CNT = (RC_CNT > CER_CNT) ? RC_CNT : CER_CNT;
    localparam int     CNT_W   = $clog2(MAX_CNT + 1);

    logic src_bit, en_bit, typ_bit;
    logic sel_hi, osc_hold, hi_seen;
    logic lo_gate, hi_gate;

    sclk_regs #(.CNT_W(CNT_W), .RC_CNT(RC_CNT), .CER_CNT(CER_CNT)) u_regs (
        .lo_clk (lo_clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .src_bit(src_bit),
        .en_bit (en_bit),
        .typ_bit(typ_bit),
        .ready  (hs_ready)
    );

    sclk_fsm u_fsm (
        .lo_clk  (lo_clk),
        .rst_n   (rst_n),
        .want_hi (src_bit & en_bit & hs_ready),
        .hi_seen (hi_seen),
        .sel_hi  (sel_hi),
        .on_hi   (on_hi),
        .osc_hold(osc_hold)
    );

    sclk_gmux #(.SYNC_N(2)) u_gmux (
        .lo_clk (lo_clk),
        .hi_clk (hi_clk),
        .rst_n  (rst_n),
        .sel_hi (sel_hi),
        .sys_clk(sys_clk),
        .lo_gate(lo_gate),
        .hi_gate(hi_gate),
        .hi_seen(hi_seen)
    );

    assign cfg_rd = {typ_bit, en_bit, src_bit};
    assign osc_on = en_bit | osc_hold;
endmodule

// File: rtl/sclk_chk.sv
module sclk_chk (
    input logic       lo_clk,
    input logic       rst_n,
    input logic [2:0] cfg_rd,
    input logic       hs_ready,
    input logic       on_hi,
    input logic       osc_on,
    input logic       lo_gate,
    input logic       hi_gate
);
    // R5
    type_lock_chk: assert property (@(posedge lo_clk) disable iff (!rst_n)
        (cfg_rd[1] && $past(cfg_rd[1])) |-> $stable(cfg_rd[2]));

    // R6
    pend_chk: assert property (@(posedge lo_clk) disable iff (!rst_n)
        $rose(on_hi) |-> hs_ready);

    // R8
    gate_excl_chk: assert property (@(posedge lo_clk) disable iff (!rst_n)
        !(lo_gate && hi_gate));

    // R9
    osc_order_chk: assert property (@(posedge lo_clk) disable iff (!rst_n)
        $fell(osc_on) |-> (!hi_gate && !on_hi));

    // R10
    ready_src_chk: assert property (@(posedge lo_clk) disable iff (!rst_n)
        $rose(hs_ready) |-> $past(cfg_rd[1]));
endmodule

bind sysclk_ctrl sclk_chk u_chk (
    .lo_clk  (lo_clk),
    .rst_n   (rst_n),
    .cfg_rd  (cfg_rd),
    .hs_ready(hs_ready),
    .on_hi   (on_hi),
    .osc_on  (osc_on),
    .lo_gate (lo_gate),
    .hi_gate (hi_gate)
);

// File: tb/sim_sysclk_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_ctrl;
    localparam int  LO_HZ  = 125000000;
    localparam int  RC_US  = 1;
    localparam int  CER_US = 4;
    localparam int  RC_N   = (LO_HZ / 1000000) * RC_US;
    localparam int  CER_N  = (LO_HZ / 1000000) * CER_US;
    localparam real LO_P   = 8.0;
    localparam real HI_P   = 3.4;

    logic lo_clk = 1'b0, hi_clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic [2:0] cfg_rd;
    logic hs_ready, on_hi, osc_on, sys_clk;

    int total = 0, bad = 0;
    bit done = 0;
    realtime last_t = 0.0, min_ph = 1.0e9;
    bit mon_on = 0;

    always #(LO_P/2) lo_clk = ~lo_clk;
    initial begin
        #0.7;
        forever #(HI_P/2) hi_clk = ~hi_clk;
    end

    sysclk_ctrl #(.LO_HZ(LO_HZ), .RC_US(RC_US), .CER_US(CER_US)) u0 (
        .lo_clk(lo_clk), .hi_clk(hi_clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_rd(cfg_rd), .hs_ready(hs_ready),
        .on_hi(on_hi), .osc_on(osc_on), .sys_clk(sys_clk)
    );

    // R8 phase-width monitor
    always @(sys_clk) begin
        if (mon_on && ($realtime - last_t) < min_ph) min_ph = $realtime - last_t;
        last_t = $realtime;
    end

    // R9 ordering monitor
    int order_bad = 0;
    always @(negedge lo_clk) if (rst_n && !osc_on && on_hi) order_bad++;

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] d);
        @(negedge lo_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge lo_clk);
        wr_en = 1'b0;
    endtask

    task automatic period(output realtime p);
        realtime t0;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); p = $realtime - t0;
    endtask

    task automatic wait_hi(logic v);
        for (int i = 0; i < 20 && on_hi != v; i++) @(negedge lo_clk);
    endtask

    task automatic ready_timing(string req, int n);
        chk({req, " ready low at start"}, hs_ready, 0);
        repeat (n - 1) @(negedge lo_clk);
        chk({req, " ready low at n-1"}, hs_ready, 0);
        chk("R6 no switch before ready", on_hi, 0);
        @(negedge lo_clk);
        chk({req, " ready high at n"}, hs_ready, 1);
    endtask

    initial begin
        realtime p;
        repeat (5) @(negedge lo_clk);
        rst_n = 1'b1;
        @(negedge lo_clk);
        mon_on = 1;
        chk("R1 cfg", cfg_rd, 0);
        chk("R1 ready", hs_ready, 0);
        chk("R1 on_hi", on_hi, 0);
        chk("R1 osc_on", osc_on, 0);
        period(p);
        chk("R1 lo period ps", longint'(p * 1000.0), longint'(LO_P * 1000.0));

        wr(3'b100);
        chk("R2 type bit2", cfg_rd, 3'b100);
        wr(3'b001);
        chk("R2 src bit0", cfg_rd, 3'b001);
        chk("R6 src without enable", on_hi, 0);
        wr(3'b000);

        wr(3'b010);
        chk("R2 enable bit1", cfg_rd, 3'b010);
        chk("R9 osc_on follows enable", osc_on, 1);
        ready_timing("R3", RC_N);
        wr(3'b110);
        chk("R5 type locked", cfg_rd, 3'b010);
        chk("R5 ready kept", hs_ready, 1);

        wr(3'b011);
        wait_hi(1'b1);
        chk("R6 on_hi after request", on_hi, 1);
        repeat (4) @(negedge lo_clk);
        period(p);
        chk("R7 hi period ps", longint'(p * 1000.0), longint'(HI_P * 1000.0));

        wr(3'b001);
        chk("R10 ready drops", hs_ready, 0);
        chk("R9 osc held while hi", osc_on, 1);
        wait_hi(1'b0);
        chk("R9 fallback done", on_hi, 0);
        for (int i = 0; i < 20 && osc_on; i++) @(negedge lo_clk);
        chk("R9 osc stops after", osc_on, 0);
        period(p);
        chk("R7 lo period back ps", longint'(p * 1000.0), longint'(LO_P * 1000.0));

        wr(3'b000);
        wr(3'b101);
        chk("R2 type with enable off", cfg_rd, 3'b101);
        wr(3'b111);
        ready_timing("R4", CER_N);
        wait_hi(1'b1);
        chk("R6 pending request taken", on_hi, 1);

        wr(3'b110);
        wait_hi(1'b0);
        chk("R11 on_hi falls", on_hi, 0);
        chk("R11 osc kept", osc_on, 1);
        chk("R11 ready kept", hs_ready, 1);
        repeat (4) @(negedge lo_clk);
        period(p);
        chk("R11 lo period ps", longint'(p * 1000.0), longint'(LO_P * 1000.0));
        wr(3'b000);
        chk("R10 ready cleared", hs_ready, 0);

        chk("R9 no hi while osc off", order_bad, 0);
        chk("R8 min phase ok", (min_ph >= HI_P/2 - 0.01) ? 1 : 0, 1);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * LO_P);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule